// File: doc/BRIEF.md
# Modem Line Interrupt and Wake Mask

This block watches four modem control inputs of a serial port: clear-to-send, data-set-ready, data-carrier-detect and ring indicator. Each input passes through a two-flop synchronizer. Any change of level on clear-to-send, data-set-ready or carrier-detect counts as an event. The ring indicator counts only on its trailing edge, the fall of the active-high ring input. Each event sets a sticky delta flag. The flags are cleared by a read strobe from the modem status register. From the flags the block raises a level-4 modem-status interrupt request. From the raw events it raises a wake request for an external sleep controller.

A five-bit mask register is written through a simple register port. Its low four bits each block one source, both from the interrupt and from the wake path. Its fifth bit blocks every wake-up. After reset the mask is zero, so the block behaves like a plain UART modem-status unit.

The interrupt request comes from a two-state machine. IRQ_IDLE moves to IRQ_PEND when an unmasked flag is set and the modem interrupt enable is high; this transition is called raise. IRQ_PEND returns to IRQ_IDLE as soon as that condition is gone, whether because the flags were read, the mask was set or the enable was dropped; this transition is called drop. In all other cases the machine stays in its state (hold). The wake request is combinational from the synchronized edge detection, so it does not depend on any interrupt state.

Top module: `modem_wake_mask`

## Requirements
- R1: After reset the mask reads 0x00, and the delta flags, the interrupt request and the wake request are all 0.
- R2: A level change in either direction on CTS, DSR or DCD sets delta flag bit 0, 1 or 3 respectively on the third rising clock edge after the input changes. Flags stay set until they are cleared.
- R3: The RI flag (bit 2) is set only by a 1-to-0 transition of the RI input. A 0-to-1 transition leaves it clear and does not request a wake.
- R4: A one-cycle read strobe clears all delta flags on the next edge. If a new event lands on that same edge, the flag for that event stays set.
- R5: With the enable high, the interrupt request rises one edge after an unmasked flag is set. It falls one edge after no unmasked flag remains or the enable drops.
- R6: Mask bits 3:0 (bit 0 CTS, bit 1 DSR, bit 2 RI, bit 3 DCD) stop that source from raising the interrupt. The flag itself is still set.
- R7: With the modem interrupt enable low, the interrupt request stays 0 whatever flags are set.
- R8: An unmasked event raises the wake request for exactly one cycle, from the second to the third edge after the input change, whatever the interrupt enable is.
- R9: Mask bit 4 set suppresses every wake request.
- R10: Mask bits 3:0 also stop their source from raising the wake request.
- R11: Writes store mask bits 4:0. Bits 7:5 are reserved and always read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cts_i | input | 1 | Clear-to-send line, asynchronous |
| dsr_i | input | 1 | Data-set-ready line, asynchronous |
| ri_i | input | 1 | Ring indicator line, active high, asynchronous |
| dcd_i | input | 1 | Carrier-detect line, asynchronous |
| ier_modem_en_i | input | 1 | Modem-status interrupt enable |
| msr_rd_i | input | 1 | Read strobe of the modem status register; clears the flags |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 8 | Mask write data |
| mask_rdata_o | output | 8 | Mask read data; bits 7:5 are always 0 |
| delta_flags_o | output | 4 | Sticky flags {DCD, RI, DSR, CTS} |
| irq_o | output | 1 | Level-4 interrupt request |
| wake_o | output | 1 | Wake request for the sleep controller |

## Verification
Take an input change driven just after edge N. The wake request is due in the cycle after edge N+2 and must be low again after edge N+3. The flag is due after edge N+3 and the interrupt after edge N+4. A read strobe or mask write applied before edge M shows on the flags or mask read-back after edge M, and on the interrupt after edge M+1. Each stimulus task pushes its expected values into a queue, tagged with the exact cycle they are due. A monitor compares them at the falling edge of that cycle, which keeps every comparison off the edge where the outputs move.

// File: rtl/mml_pkg.sv
package mml_pkg;
    localparam int LINE_N       = 4;
    localparam int IDX_CTS      = 0;
    localparam int IDX_DSR      = 1;
    localparam int IDX_RI       = 2;
    localparam int IDX_DCD      = 3;
    localparam int WAKE_OFF_BIT = LINE_N;
    localparam int LIVE_W       = LINE_N + 1;

    typedef enum logic [0:0] {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_e;
endpackage

// File: rtl/mml_line_edge.sv
module mml_line_edge #(
    parameter int SYNC_STAGES = 2,
    parameter bit TRAIL_ONLY  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic event_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cur;

    assign cur = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            prev_q <= cur;
        end
    end

    generate
        if (TRAIL_ONLY) begin : g_trail
            assign event_o = prev_q & ~cur;
        end else begin : g_any
            assign event_o = prev_q ^ cur;
        end
    endgenerate
endmodule

// File: rtl/mml_mask_reg.sv
module mml_mask_reg #(
    parameter int MASK_W = 8,
    parameter int LIVE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [MASK_W-1:0] wdata_i,
    output logic [LIVE_W-1:0] mask_o,
    output logic [MASK_W-1:0] rdata_o
);
    localparam int RESV_W = MASK_W - LIVE_W;

    logic [LIVE_W-1:0] mask_q;
    logic              unused_resv;

    assign unused_resv = ^wdata_i[MASK_W-1:LIVE_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_i) begin
            mask_q <= wdata_i[LIVE_W-1:0];
        end
    end

    assign mask_o  = mask_q;
    assign rdata_o = {{RESV_W{1'b0}}, mask_q};
endmodule

// File: rtl/mml_delta_latch.sv
module mml_delta_latch #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] event_i,
    input  logic         clr_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flags_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (clr_i ? '0 : flags_q) | event_i;
        end
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/mml_irq_fsm.sv
module mml_irq_fsm
    import mml_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    output logic irq_o
);
    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (pending_i)  state_d = IRQ_PEND;
            IRQ_PEND: if (!pending_i) state_d = IRQ_IDLE;
            default:  state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq_o = 1'b0;
        unique case (state_q)
            IRQ_IDLE: irq_o = 1'b0;
            IRQ_PEND: irq_o = 1'b1;
            default:  irq_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/modem_wake_mask.sv
module modem_wake_mask
    import mml_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MASK_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cts_i,
    input  logic              dsr_i,
    input  logic              ri_i,
    input  logic              dcd_i,
    input  logic              ier_modem_en_i,
    input  logic              msr_rd_i,
    input  logic              mask_wr_i,
    input  logic [MASK_W-1:0] mask_wdata_i,
    output logic [MASK_W-1:0] mask_rdata_o,
    output logic [LINE_N-1:0] delta_flags_o,
    output logic              irq_o,
    output logic              wake_o
);
    logic [LINE_N-1:0] lines;
    logic [LINE_N-1:0] events;
    logic [LINE_N-1:0] src_en;
    logic [LIVE_W-1:0] mask;
    logic              pending;

    assign lines = {dcd_i, ri_i, dsr_i, cts_i};

    generate
        for (genvar g = 0; g < LINE_N; g++) begin : g_line
            mml_line_edge #(
                .SYNC_STAGES(SYNC_STAGES),
                .TRAIL_ONLY (g == IDX_RI)
            ) edge_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .line_i (lines[g]),
                .event_o(events[g])
            );
        end
    endgenerate

    mml_mask_reg #(
        .MASK_W(MASK_W),
        .LIVE_W(LIVE_W)
    ) mask_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (mask_wr_i),
        .wdata_i(mask_wdata_i),
        .mask_o (mask),
        .rdata_o(mask_rdata_o)
    );

    mml_delta_latch #(
        .N(LINE_N)
    ) latch_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .event_i(events),
        .clr_i  (msr_rd_i),
        .flags_o(delta_flags_o)
    );

    assign src_en  = ~mask[LINE_N-1:0];
    assign pending = ier_modem_en_i & |(delta_flags_o & src_en);
    assign wake_o  = ~mask[WAKE_OFF_BIT] & |(events & src_en);

    mml_irq_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pending_i(pending),
        .irq_o    (irq_o)
    );
endmodule

// File: rtl/mml_checker.sv
module mml_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ier_modem_en_i,
    input logic       msr_rd_i,
    input logic [7:0] mask_rdata_o,
    input logic [3:0] delta_flags_o,
    input logic       irq_o,
    input logic       wake_o
);
    p_resv_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mask_rdata_o[7:5] == 3'b000);

    p_wake_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mask_rdata_o[4] |-> !wake_o);

    p_no_en_no_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ier_modem_en_i |=> !irq_o);

    p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(ier_modem_en_i && ((delta_flags_o & ~mask_rdata_o[3:0]) != 4'b0)));

    p_flags_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !msr_rd_i |=> ((delta_flags_o & $past(delta_flags_o)) == $past(delta_flags_o)));

    p_wake_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o && $past(wake_o) |-> ($past(mask_rdata_o) == mask_rdata_o));
endmodule

bind modem_wake_mask mml_checker chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ier_modem_en_i(ier_modem_en_i),
    .msr_rd_i      (msr_rd_i),
    .mask_rdata_o  (mask_rdata_o),
    .delta_flags_o (delta_flags_o),
    .irq_o         (irq_o),
    .wake_o        (wake_o)
);

// File: tb/modem_wake_mask_tb.sv
module modem_wake_mask_tb_top;
    localparam int K_FLAGS = 0;
    localparam int K_IRQ   = 1;
    localparam int K_WAKE  = 2;
    localparam int K_RDATA = 3;

    typedef struct {
        int         due;
        int         kind;
        logic [7:0] val;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cts = 1'b0, dsr = 1'b0, ri = 1'b0, dcd = 1'b0;
    logic       ier_en = 1'b0, msr_rd = 1'b0, mask_wr = 1'b0;
    logic [7:0] mask_wdata = 8'h00;
    logic [7:0] mask_rdata;
    logic [3:0] flags;
    logic       irq, wake;

    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    exp_t q[$];

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    modem_wake_mask dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cts_i         (cts),
        .dsr_i         (dsr),
        .ri_i          (ri),
        .dcd_i         (dcd),
        .ier_modem_en_i(ier_en),
        .msr_rd_i      (msr_rd),
        .mask_wr_i     (mask_wr),
        .mask_wdata_i  (mask_wdata),
        .mask_rdata_o  (mask_rdata),
        .delta_flags_o (flags),
        .irq_o         (irq),
        .wake_o        (wake)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s cyc=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
        end
    endtask

    // monitor: pops due items at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            logic [7:0] act;
            e = q.pop_front();
            case (e.kind)
                K_FLAGS: act = {4'h0, flags};
                K_IRQ:   act = {7'h0, irq};
                K_WAKE:  act = {7'h0, wake};
                default: act = mask_rdata;
            endcase
            check(e.tag, act, e.val);
        end
    end

    task automatic expect_at(int off, int kind, logic [7:0] v, string tag);
        exp_t e;
        int   pos;
        e.due = cyc + off;
        e.kind = kind;
        e.val = v;
        e.tag = tag;
        pos = q.size();
        for (int i = 0; i < q.size(); i++) begin
            if (q[i].due > e.due) begin
                pos = i;
                break;
            end
        end
        q.insert(pos, e);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_line(int idx, logic v);
        @(negedge clk);
        case (idx)
            0: cts = v;
            1: dsr = v;
            2: ri  = v;
            default: dcd = v;
        endcase
    endtask

    task automatic write_mask(logic [7:0] v, logic [7:0] rb);
        @(negedge clk);
        mask_wr = 1'b1;
        mask_wdata = v;
        expect_at(1, K_RDATA, rb, "R11 mask readback");
        @(negedge clk);
        mask_wr = 1'b0;
    endtask

    task automatic read_msr();
        @(negedge clk);
        msr_rd = 1'b1;
        expect_at(1, K_FLAGS, 8'h00, "R4 read clears flags");
        expect_at(2, K_IRQ, 8'h00, "R5 irq drops after clear");
        @(negedge clk);
        msr_rd = 1'b0;
        idle(3);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        expect_at(1, K_FLAGS, 8'h00, "R1 reset flags");
        expect_at(1, K_IRQ,   8'h00, "R1 reset irq");
        expect_at(1, K_WAKE,  8'h00, "R1 reset wake");
        expect_at(1, K_RDATA, 8'h00, "R1 reset mask");
        idle(2);
        ier_en = 1'b1;

        // CTS rise, all unmasked
        drive_line(0, 1'b1);
        expect_at(2, K_WAKE,  8'h01, "R8 wake on CTS");
        expect_at(3, K_WAKE,  8'h00, "R8 wake one cycle");
        expect_at(3, K_FLAGS, 8'h01, "R2 CTS flag");
        expect_at(4, K_IRQ,   8'h01, "R5 irq raise");
        idle(6);
        read_msr();

        // RI rise must not count, RI fall must
        drive_line(2, 1'b1);
        expect_at(2, K_WAKE,  8'h00, "R3 RI rise no wake");
        expect_at(3, K_FLAGS, 8'h00, "R3 RI rise no flag");
        idle(5);
        drive_line(2, 1'b0);
        expect_at(2, K_WAKE,  8'h01, "R3 RI fall wake");
        expect_at(3, K_FLAGS, 8'h04, "R3 RI fall flag");
        idle(6);
        read_msr();

        // mask CTS
        write_mask(8'h01, 8'h01);
        drive_line(0, 1'b0);
        expect_at(2, K_WAKE,  8'h00, "R10 masked CTS no wake");
        expect_at(3, K_FLAGS, 8'h01, "R6 masked flag still set");
        expect_at(4, K_IRQ,   8'h00, "R6 masked no irq");
        expect_at(6, K_IRQ,   8'h00, "R6 masked no irq later");
        idle(7);
        read_msr();

        // reserved bits and global wake disable
        write_mask(8'hFF, 8'h1F);
        write_mask(8'h10, 8'h10);
        drive_line(1, 1'b1);
        expect_at(2, K_WAKE,  8'h00, "R9 global wake off");
        expect_at(3, K_FLAGS, 8'h02, "R2 DSR flag");
        expect_at(4, K_IRQ,   8'h01, "R5 irq with wake off");
        idle(6);
        read_msr();

        // enable low
        write_mask(8'h00, 8'h00);
        @(negedge clk);
        ier_en = 1'b0;
        drive_line(3, 1'b1);
        expect_at(2, K_WAKE,  8'h01, "R8 wake without enable");
        expect_at(3, K_FLAGS, 8'h08, "R2 DCD flag");
        expect_at(4, K_IRQ,   8'h00, "R7 no irq enable low");
        idle(6);
        @(negedge clk);
        ier_en = 1'b1;
        expect_at(1, K_IRQ, 8'h01, "R5 irq on enable");
        idle(3);
        read_msr();

        // clear and new event on the same edge
        drive_line(0, 1'b1);
        expect_at(3, K_FLAGS, 8'h01, "R4 set wins over clear");
        expect_at(4, K_IRQ,   8'h01, "R5 irq after collision");
        idle(1);
        @(negedge clk);
        msr_rd = 1'b1;
        @(negedge clk);
        msr_rd = 1'b0;
        idle(4);
        read_msr();

        idle(2);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done && q.size() == 0);
            end
            begin
                repeat (20000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog expired pending=%0d", q.size());
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule